// File: doc/BRIEF.md
# Debug Exception Policy Unit

This block decides, from the processor's current privilege state, whether debug exceptions may be taken at all and which privilege level receives them. It reads the current level, the security state, a width flag for each level (64-bit or 32-bit execution), the hypervisor and monitor debug controls, the two lock bits, the kernel-debug enable, the debug mask bit and the single-step enable. From these it produces the debug target level, a global enable, a single-step-active flag, a syndrome flag that marks a same-level exception, and the level at which a software breakpoint instruction is taken.

There is no state inside the block. Every output is a pure function of the inputs. The exception-entry logic, the breakpoint and watchpoint comparators and the single-step sequencer all consult it on each cycle. It has two rule sets: one for 64-bit execution, which compares the target level with the current level, and one for 32-bit execution, which uses a 2-bit secure privileged-debug code. On top of both sit the lock overrides and the secure-disable controls.

Levels are coded 0 (user), 1 (kernel), 2 (hypervisor) and 3 (monitor).

Top module: `dbg_exc_policy`

## Requirements
- R1: The target level is 2 when `hyp_on` is set and either `hyp_trap_ge` or `hyp_trap_dbg` is set. Otherwise it is 3 when `mon_on` is set, level 3 is 32-bit (`lvl_is64[3]`=0) and `secure` is set. In every other case it is 1.
- R2: While `os_lock` or `dbl_lock` is set, `dbg_en` and `sstep_active` are 0, whatever the other inputs are.
- R3: Under the 64-bit rules, when `secure` is set and the current level is below 3, setting `mon_sec_dis` forces `dbg_en` to 0.
- R4: Under the 64-bit rules, when the target level equals the current level, `dbg_en` is 1 only if `kdbg_en` is 1 and `dbg_mask` is 0.
- R5: Under the 64-bit rules, when the target level differs from the current level, `dbg_en` is 1 only if the target level is strictly higher than the current level.
- R6: The 64-bit rules apply when the current level is 64-bit, and also at level 0 whenever level 1 is 64-bit. The 32-bit rules apply in all other cases.
- R7: Under the 32-bit rules in secure state, `mon_spd` decides the enable: code 2'b10 disables, and codes 2'b00, 2'b01 and 2'b11 enable.
- R8: Under the 32-bit rules in secure state at level 0, `suser_dbg_en`=1 enables debug exceptions even when `mon_spd` is 2'b10.
- R9: Under the 32-bit rules in non-secure state, `dbg_en` is 1 at every current level except level 2.
- R10: `sstep_active` is 1 exactly when `sstep_en` is set, the target level is 64-bit and `dbg_en` is 1.
- R11: `syn_same_lvl` is 1 exactly when the target level equals the current level.
- R12: `brk_lvl` equals the target level when that is not below the current level. Otherwise it equals the current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_lvl | input | 2 | Current privilege level |
| secure | input | 1 | Processor is in secure state |
| lvl_is64 | input | 4 | Bit n set: level n executes in 64-bit mode |
| hyp_on | input | 1 | Hypervisor level enabled in the current state |
| hyp_trap_ge | input | 1 | Hypervisor traps general exceptions |
| hyp_trap_dbg | input | 1 | Hypervisor traps debug exceptions |
| mon_on | input | 1 | Monitor level implemented |
| mon_sec_dis | input | 1 | Monitor control: disable debug from secure state (64-bit rules) |
| mon_spd | input | 2 | Monitor control: secure privileged-debug code (32-bit rules) |
| kdbg_en | input | 1 | Kernel debug enable for same-level debug |
| dbg_mask | input | 1 | Debug exception mask bit |
| sstep_en | input | 1 | Software single-step enable |
| os_lock | input | 1 | OS lock status |
| dbl_lock | input | 1 | Double-lock status |
| suser_dbg_en | input | 1 | Secure user-level debug enable |
| tgt_lvl | output | 2 | Debug exception target level |
| dbg_en | output | 1 | Debug exceptions may be generated |
| sstep_active | output | 1 | Single-step is active |
| syn_same_lvl | output | 1 | Syndrome flag: exception stays at the current level |
| brk_lvl | output | 2 | Level that takes a software breakpoint instruction |

## Verification
Every output is combinational, so each result is due in the same cycle as its stimulus, with no register on the path. The driver applies one input pattern just after a rising edge and queues the expected outputs, which come from a model built on the requirements. The monitor pops that entry at the next falling edge, half a cycle later, and compares all five outputs. Each queued item is therefore matched to exactly the stimulus that produced it, and the inputs have settled before any comparison is made.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;

    localparam int NUM_LVL = 4;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int SPD_W   = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_USR = 2'd0,
        LVL_KRN = 2'd1,
        LVL_HYP = 2'd2,
        LVL_MON = 2'd3
    } lvl_e;

    typedef enum logic [SPD_W-1:0] {
        SPD_DFLT = 2'b00,
        SPD_RSVD = 2'b01,
        SPD_OFF  = 2'b10,
        SPD_ON   = 2'b11
    } spd_e;

    // Routing controls gathered for the target selector
    typedef struct packed {
        logic hyp_on;
        logic trap_ge;
        logic trap_dbg;
        logic mon_on;
        logic mon_is64;
        logic secure;
    } route_ctl_t;

    // Controls consumed by the enable gate
    typedef struct packed {
        logic secure;
        logic sec_dis;
        spd_e spd;
        logic kdbg_en;
        logic mask;
        logic os_lock;
        logic dbl_lock;
        logic suser_en;
    } gate_ctl_t;

    // Secondary results derived from the target and enable
    typedef struct packed {
        logic sstep;
        logic same_lvl;
        lvl_e brk;
    } step_out_t;

    function automatic lvl_e lvl_max(input lvl_e a, input lvl_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dbgx_route.sv
module dbgx_route
    import dbgx_pkg::*;
(
    input  route_ctl_t ctl,
    output lvl_e       tgt
);
    logic hyp_claims;
    logic mon_claims;

    always_comb begin
        hyp_claims = ctl.hyp_on && (ctl.trap_ge || ctl.trap_dbg);
        mon_claims = ctl.mon_on && !ctl.mon_is64 && ctl.secure;
        if (hyp_claims)
            tgt = LVL_HYP;
        else if (mon_claims)
            tgt = LVL_MON;
        else
            tgt = LVL_KRN;
    end
endmodule

// File: rtl/dbgx_gate.sv
module dbgx_gate
    import dbgx_pkg::*;
(
    input  lvl_e             cur,
    input  lvl_e             tgt,
    input  logic [NUM_LVL-1:0] lvl_is64,
    input  gate_ctl_t        ctl,
    output logic             en
);
    logic [LVL_W-1:0] cur_idx;
    logic use64;
    logic en64;
    logic en32;
    logic locked;

    always_comb begin
        cur_idx = cur;
        // Level 0 follows the 64-bit rules when its kernel runs 64-bit
        use64 = lvl_is64[cur_idx] || ((cur == LVL_USR) && lvl_is64[1]);

        if (ctl.secure && (cur != LVL_MON) && ctl.sec_dis)
            en64 = 1'b0;
        else if (tgt == cur)
            en64 = ctl.kdbg_en && !ctl.mask;
        else
            en64 = (tgt > cur);

        if (ctl.secure) begin
            if ((cur == LVL_USR) && ctl.suser_en)
                en32 = 1'b1;
            else
                en32 = (ctl.spd != SPD_OFF);
        end else begin
            en32 = (cur != LVL_HYP);
        end

        locked = ctl.os_lock || ctl.dbl_lock;
        en = !locked && (use64 ? en64 : en32);
    end
endmodule

// File: rtl/dbgx_step.sv
module dbgx_step
    import dbgx_pkg::*;
(
    input  lvl_e               cur,
    input  lvl_e               tgt,
    input  logic [NUM_LVL-1:0] lvl_is64,
    input  logic               sstep_en,
    input  logic               en,
    output step_out_t          res
);
    logic [LVL_W-1:0] tgt_idx;

    always_comb begin
        tgt_idx      = tgt;
        res.sstep    = sstep_en && lvl_is64[tgt_idx] && en;
        res.same_lvl = (tgt == cur);
        res.brk      = lvl_max(tgt, cur);
    end
endmodule

// File: rtl/dbg_exc_policy.sv
module dbg_exc_policy
    import dbgx_pkg::*;
(
    input  logic [1:0] cur_lvl,
    input  logic       secure,
    input  logic [3:0] lvl_is64,
    input  logic       hyp_on,
    input  logic       hyp_trap_ge,
    input  logic       hyp_trap_dbg,
    input  logic       mon_on,
    input  logic       mon_sec_dis,
    input  logic [1:0] mon_spd,
    input  logic       kdbg_en,
    input  logic       dbg_mask,
    input  logic       sstep_en,
    input  logic       os_lock,
    input  logic       dbl_lock,
    input  logic       suser_dbg_en,
    output logic [1:0] tgt_lvl,
    output logic       dbg_en,
    output logic       sstep_active,
    output logic       syn_same_lvl,
    output logic [1:0] brk_lvl
);
    route_ctl_t rctl;
    gate_ctl_t  gctl;
    lvl_e       cur;
    lvl_e       tgt;
    logic       en;
    step_out_t  sres;

    always_comb begin
        cur           = lvl_e'(cur_lvl);
        rctl.hyp_on   = hyp_on;
        rctl.trap_ge  = hyp_trap_ge;
        rctl.trap_dbg = hyp_trap_dbg;
        rctl.mon_on   = mon_on;
        rctl.mon_is64 = lvl_is64[3];
        rctl.secure   = secure;

        gctl.secure   = secure;
        gctl.sec_dis  = mon_sec_dis;
        gctl.spd      = spd_e'(mon_spd);
        gctl.kdbg_en  = kdbg_en;
        gctl.mask     = dbg_mask;
        gctl.os_lock  = os_lock;
        gctl.dbl_lock = dbl_lock;
        gctl.suser_en = suser_dbg_en;
    end

    dbgx_route u_route (
        .ctl (rctl),
        .tgt (tgt)
    );

    dbgx_gate u_gate (
        .cur      (cur),
        .tgt      (tgt),
        .lvl_is64 (lvl_is64),
        .ctl      (gctl),
        .en       (en)
    );

    dbgx_step u_step (
        .cur      (cur),
        .tgt      (tgt),
        .lvl_is64 (lvl_is64),
        .sstep_en (sstep_en),
        .en       (en),
        .res      (sres)
    );

    assign tgt_lvl      = tgt;
    assign dbg_en       = en;
    assign sstep_active = sres.sstep;
    assign syn_same_lvl = sres.same_lvl;
    assign brk_lvl      = sres.brk;
endmodule

// File: rtl/dbg_exc_policy_chk.sv
module dbg_exc_policy_chk (
    input logic [1:0] cur_lvl,
    input logic [3:0] lvl_is64,
    input logic       hyp_on,
    input logic       sstep_en,
    input logic       os_lock,
    input logic       dbl_lock,
    input logic [1:0] tgt_lvl,
    input logic       dbg_en,
    input logic       sstep_active,
    input logic       syn_same_lvl,
    input logic [1:0] brk_lvl
);
    always_comb begin
        a_r2_lock_blocks: assert (!(os_lock || dbl_lock) || (!dbg_en && !sstep_active))
            else $error("lock did not block debug");
        a_r10_step_gated: assert (!sstep_active || (dbg_en && sstep_en && lvl_is64[tgt_lvl]))
            else $error("single-step active without its conditions");
        a_r1_tgt_never_user: assert (tgt_lvl != 2'd0)
            else $error("debug routed to level 0");
        a_r1_hyp_route: assert ((tgt_lvl != 2'd2) || hyp_on)
            else $error("routed to hypervisor level while it is off");
        a_r11_syn_same: assert (!syn_same_lvl || (tgt_lvl == cur_lvl))
            else $error("same-level flag with differing levels");
        a_r12_brk_floor: assert ((brk_lvl >= cur_lvl) && ((brk_lvl == tgt_lvl) || (brk_lvl == cur_lvl)))
            else $error("breakpoint level below current or unrelated");
    end
endmodule

bind dbg_exc_policy dbg_exc_policy_chk u_chk (
    .cur_lvl      (cur_lvl),
    .lvl_is64     (lvl_is64),
    .hyp_on       (hyp_on),
    .sstep_en     (sstep_en),
    .os_lock      (os_lock),
    .dbl_lock     (dbl_lock),
    .tgt_lvl      (tgt_lvl),
    .dbg_en       (dbg_en),
    .sstep_active (sstep_active),
    .syn_same_lvl (syn_same_lvl),
    .brk_lvl      (brk_lvl)
);

// File: tb/tb_dbg_exc_policy.sv
`timescale 1ns/1ps
module tb_dbg_exc_policy;

    typedef struct packed {
        logic [1:0] cur;
        logic       sec;
        logic [3:0] is64;
        logic       hyp, tge, tde, mon, sdd;
        logic [1:0] spd;
        logic       kde, mask, ss, osl, dlk, suid;
    } stim_t;

    typedef struct {
        string      tag;
        logic [1:0] tgt;
        logic       en, ss, syn;
        logic [1:0] brk;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    stim_t s_in = '0;
    logic [1:0] tgt_lvl, brk_lvl;
    logic dbg_en, sstep_active, syn_same_lvl;

    dbg_exc_policy dut (
        .cur_lvl(s_in.cur), .secure(s_in.sec), .lvl_is64(s_in.is64),
        .hyp_on(s_in.hyp), .hyp_trap_ge(s_in.tge), .hyp_trap_dbg(s_in.tde),
        .mon_on(s_in.mon), .mon_sec_dis(s_in.sdd), .mon_spd(s_in.spd),
        .kdbg_en(s_in.kde), .dbg_mask(s_in.mask), .sstep_en(s_in.ss),
        .os_lock(s_in.osl), .dbl_lock(s_in.dlk), .suser_dbg_en(s_in.suid),
        .tgt_lvl(tgt_lvl), .dbg_en(dbg_en), .sstep_active(sstep_active),
        .syn_same_lvl(syn_same_lvl), .brk_lvl(brk_lvl)
    );

    exp_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Expected outputs built from the requirement text
    function automatic exp_t model(input string tag, input stim_t s);
        exp_t e;
        logic use64;
        e.tag = tag;
        if (s.hyp && (s.tge || s.tde))            e.tgt = 2'd2;   // R1
        else if (s.mon && !s.is64[3] && s.sec)    e.tgt = 2'd3;
        else                                      e.tgt = 2'd1;
        use64 = s.is64[s.cur] || (s.cur == 2'd0 && s.is64[1]); // R6
        if (use64) begin
            if (s.sec && s.cur != 2'd3 && s.sdd)  e.en = 1'b0;    // R3
            else if (e.tgt == s.cur)              e.en = s.kde && !s.mask; // R4
            else                                  e.en = (e.tgt > s.cur);  // R5
        end else if (s.sec) begin
            e.en = (s.cur == 2'd0 && s.suid) || (s.spd != 2'b10); // R7 R8
        end else begin
            e.en = (s.cur != 2'd2);                                // R9
        end
        if (s.osl || s.dlk) e.en = 1'b0;                           // R2
        e.ss  = s.ss && s.is64[e.tgt] && e.en;                     // R10
        e.syn = (e.tgt == s.cur);                                  // R11
        e.brk = (e.tgt < s.cur) ? s.cur : e.tgt;                   // R12
        return e;
    endfunction

    task automatic drive(input string tag, input stim_t s);
        @(posedge clk);
        s_in = s;
        q.push_back(model(tag, s));
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: combinational result is due half a cycle after the drive edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "tgt_lvl",      int'(tgt_lvl),      int'(e.tgt));
                cmp(e.tag, "dbg_en",       int'(dbg_en),       int'(e.en));
                cmp(e.tag, "sstep_active", int'(sstep_active), int'(e.ss));
                cmp(e.tag, "syn_same_lvl", int'(syn_same_lvl), int'(e.syn));
                cmp(e.tag, "brk_lvl",      int'(brk_lvl),      int'(e.brk));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        s = '0;                                   drive("R1 reset state", s);
        s = '0; s.cur=1; s.is64=4'hF; s.hyp=1; s.tge=1;  drive("R1 hyp general trap", s);
        s = '0; s.cur=0; s.is64=4'hF; s.hyp=1; s.tde=1;  drive("R1 hyp debug trap", s);
        s = '0; s.cur=1; s.sec=1; s.mon=1;               drive("R1 secure monitor 32-bit", s);
        s = '0; s.cur=1; s.sec=1; s.mon=1; s.is64=4'h8;  drive("R1 monitor 64-bit no claim", s);
        s = '0; s.cur=1; s.is64=4'hF; s.kde=1; s.osl=1; s.ss=1; drive("R2 os lock", s);
        s = '0; s.cur=0; s.is64=4'hF; s.dlk=1; s.ss=1;   drive("R2 double lock", s);
        s = '0; s.cur=1; s.sec=1; s.is64=4'hF; s.hyp=1; s.tge=1; s.sdd=1; drive("R3 secure disable", s);
        s = '0; s.cur=1; s.sec=1; s.is64=4'hF; s.hyp=1; s.tge=1;          drive("R3 secure no disable", s);
        s = '0; s.cur=1; s.is64=4'hF; s.kde=1;           drive("R4 same level enabled", s);
        s = '0; s.cur=1; s.is64=4'hF; s.kde=1; s.mask=1; drive("R4 same level masked", s);
        s = '0; s.cur=1; s.is64=4'hF;                    drive("R4 same level no kde", s);
        s = '0; s.cur=2; s.is64=4'hF; s.kde=1;           drive("R5 target below current", s);
        s = '0; s.cur=0; s.is64=4'hF;                    drive("R5 target above current", s);
        s = '0; s.cur=0; s.is64=4'h2; s.sec=1; s.sdd=1;  drive("R6 user follows 64-bit kernel", s);
        s = '0; s.cur=0; s.is64=4'h0; s.sec=1; s.sdd=1;  drive("R6 user 32-bit path", s);
        s = '0; s.cur=1; s.sec=1; s.mon=1; s.spd=2'b01;  drive("R7 spd reserved", s);
        s = '0; s.cur=1; s.sec=1; s.mon=1; s.spd=2'b10;  drive("R7 spd off", s);
        s = '0; s.cur=1; s.sec=1; s.mon=1; s.spd=2'b11;  drive("R7 spd on", s);
        s = '0; s.cur=0; s.sec=1; s.spd=2'b10; s.suid=1; drive("R8 secure user forced", s);
        s = '0; s.cur=0; s.sec=1; s.spd=2'b10;           drive("R8 secure user follows spd", s);
        s = '0; s.cur=2;                                  drive("R9 nonsecure level 2", s);
        s = '0; s.cur=3;                                  drive("R9 nonsecure level 3", s);
        s = '0; s.cur=0; s.is64=4'hF; s.ss=1;            drive("R10 step active", s);
        s = '0; s.cur=0; s.is64=4'h1; s.ss=1;            drive("R10 step target 32-bit", s);
        s = '0; s.cur=1; s.is64=4'hF; s.ss=1;            drive("R10 step enable off", s);
        s = '0; s.cur=2; s.is64=4'hF; s.hyp=1; s.tde=1; s.kde=1; drive("R11 same level at 2", s);
        s = '0; s.cur=3; s.is64=4'hF;                    drive("R12 breakpoint at current", s);
        s = '0; s.cur=3; s.sec=1; s.mon=1;               drive("R12 breakpoint at monitor", s);

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule